// File: doc/BRIEF.md
# Quad-Channel DAC Register Interface

This block is the digital control front end of a four-channel voltage-output converter. A host talks to it as an SPI slave (clock idle low, input sampled on the rising serial-clock edge, output changed on the falling edge). Each transaction is one 24-bit word sent most significant bit first while chip select is held low. The word carries a read flag, a 7-bit address and a 16-bit data field. The upper four address bits give the register kind and the lower three give the channel. The block keeps a data code, a coarse-gain, a fine-gain and an offset register per channel, plus one configuration word and a latched output code per channel. The output codes change only on a load command.

Reading takes two frames. The frame that carries the read flag only captures the addressed value. The next chip-select frame shifts that value out on MISO while its own input word is decoded as a normal command, so an all-zero word is a harmless no-op. The serial side is a four-state link machine: LINK_IDLE (chip select high), LINK_SHIFT (fewer than 24 bits received), LINK_FULL (exactly 24 bits received) and LINK_OVER (more than 24 bits). The transitions are named as follows. *start* goes from IDLE to SHIFT on the chip-select fall. *fill* goes from SHIFT to FULL on the 24th rising clock. *overrun* goes from FULL to OVER on a 25th rising clock. *end* goes from any of SHIFT, FULL or OVER back to IDLE on the chip-select rise. Only an *end* taken from FULL commits the word. A resolution parameter selects 16-bit or 14-bit codes. A 14-bit code is left-aligned in the data field.

Top module: `quad_dac_regif`

## Requirements
- R1: Frame layout: bit 23 is the read flag, bits 22:19 the register kind, bits 18:16 the channel and bits 15:0 the data. A write (bit 23 = 0) of kind 2 to channel 0..3 sets that channel's data code to the data field.
- R2: With RES_BITS = 14, data bits 1:0 are dropped on write, so data codes and their read-back always have bits 1:0 equal to zero.
- R3: Kind 3 (coarse gain) keeps data bits 1:0. Kind 4 (fine gain, 6-bit two's complement) keeps bits 5:0. Kind 5 (offset, 8-bit two's complement) keeps bits 7:0. Higher data bits are ignored.
- R4: A frame with bit 23 set captures the addressed register. The next frame shifts out 8 zero bits and then the 16-bit value, zero-extended, MSB first. A frame that follows a committed non-read frame shifts out 24 zeros.
- R5: The input word of the frame that carries read-back data is decoded as an ordinary command. An all-zero word (kind 0, function 0) changes no register.
- R6: Kind 0 with function 4 (clear) sets every data code to mid-scale 0x8000. The output codes are unchanged.
- R7: Kind 0 with function 5 (load) copies all four data codes into the output codes in the same cycle. No other command changes an output code.
- R8: Kind 0 with function 1 (configuration) stores the 16-bit data field. A read of the same address returns it.
- R9: A frame with other than 24 rising clock edges while chip select is low is discarded. It changes no register and leaves the pending read-back value in place.
- R10: Writes to channels 4..7, or to kinds 1 and 6..15, change nothing. Reads of such addresses return zero.
- R11: After reset every data code and output code is 0x8000, the gain, offset and configuration registers are 0, and the first frame shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing each word |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial read-back data out |
| data_o | output | NCH x 16 | Per-channel data codes |
| coarse_o | output | NCH x 2 | Per-channel coarse-gain fields |
| fine_o | output | NCH x 6 | Per-channel fine-gain fields |
| offset_o | output | NCH x 8 | Per-channel offset fields |
| out_o | output | NCH x 16 | Latched output codes |
| cfg_o | output | 16 | Configuration word |

## Verification
The hardest case to reach from the ports is a read-back frame that is also a command, and the case where the pending read value must survive a discarded frame. The stimulus issues a read and follows it directly with a data write to another channel. It also follows a read with a 23-bit frame before the full-length frame that shifts the value out. Two instances, one at 16-bit and one at 14-bit resolution, share the serial bus. This shows that dropping the low bits affects only the data codes. A behavioural model is compared against every output on every clock.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W = 24;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [15:0] MID_CODE = 16'h8000;

    // register kinds (address bits 22:19)
    localparam logic [3:0] RK_SPECIAL = 4'd0;
    localparam logic [3:0] RK_DATA    = 4'd2;
    localparam logic [3:0] RK_COARSE  = 4'd3;
    localparam logic [3:0] RK_FINE    = 4'd4;
    localparam logic [3:0] RK_OFFSET  = 4'd5;

    // special functions (address bits 18:16 when kind is 0)
    localparam logic [2:0] FN_NOP   = 3'd0;
    localparam logic [2:0] FN_CFG   = 3'd1;
    localparam logic [2:0] FN_CLEAR = 3'd4;
    localparam logic [2:0] FN_LOAD  = 3'd5;

    typedef enum logic [1:0] {
        LINK_IDLE,
        LINK_SHIFT,
        LINK_FULL,
        LINK_OVER
    } link_state_t;
endpackage

// File: rtl/qdac_link.sv
module qdac_link
    import qdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                mosi,
    output logic                miso,
    input  logic [15:0]         tx_word,
    output logic                frame_v,
    output logic [FRAME_W-1:0]  frame_w
);
    link_state_t state_q, state_d;
    logic              cs_q, sclk_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAME_W-1:0] rx_q, tx_q;

    logic cs_fall, cs_rise, sck_rise, sck_fall;
    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign sck_rise = ~cs_n & sclk & ~sclk_q;
    assign sck_fall = ~cs_n & ~sclk & sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, fill, overrun, end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_IDLE:  if (cs_fall) state_d = LINK_SHIFT;
            LINK_SHIFT: begin
                if (cs_rise) state_d = LINK_IDLE;
                else if (sck_rise && cnt_q == CNT_W'(FRAME_W - 1)) state_d = LINK_FULL;
            end
            LINK_FULL: begin
                if (cs_rise) state_d = LINK_IDLE;
                else if (sck_rise) state_d = LINK_OVER;
            end
            LINK_OVER:  if (cs_rise) state_d = LINK_IDLE;
        endcase
    end

    // shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_fall) begin
                cnt_q <= '0;
                rx_q  <= '0;
                tx_q  <= {8'h00, tx_word};
            end else begin
                if (sck_rise && state_q == LINK_SHIFT) begin
                    rx_q  <= {rx_q[FRAME_W-2:0], mosi};
                    cnt_q <= cnt_q + 1'b1;
                end
                if (sck_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        frame_v = (state_q == LINK_FULL) && cs_rise;
        frame_w = rx_q;
        miso    = tx_q[FRAME_W-1];
    end

    // independent count of serial edges inside the current frame
    logic [5:0] edges_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             edges_seen <= '0;
        else if (cs_fall)                       edges_seen <= '0;
        else if (sck_rise && edges_seen != '1)  edges_seen <= edges_seen + 1'b1;
    end

    // R9
    commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_v |-> (edges_seen == 6'(FRAME_W)));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int RES_BITS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_v,
    input  logic [FRAME_W-1:0]      frame_w,
    output logic [NCH-1:0][15:0]    data_o,
    output logic [NCH-1:0][1:0]     coarse_o,
    output logic [NCH-1:0][5:0]     fine_o,
    output logic [NCH-1:0][7:0]     offset_o,
    output logic [NCH-1:0][15:0]    out_o,
    output logic [15:0]             cfg_o,
    output logic [15:0]             rdbuf_o
);
    localparam int PAD = 16 - RES_BITS;
    localparam logic [15:0] CODE_MASK = 16'hFFFF << PAD;

    logic        rd;
    logic [3:0]  kind;
    logic [2:0]  sel;
    logic [15:0] val;
    assign {rd, kind, sel, val} = frame_w;

    logic wr, do_clear, do_load, do_cfg;
    assign wr       = frame_v & ~rd;
    assign do_clear = wr && kind == RK_SPECIAL && sel == FN_CLEAR;
    assign do_load  = wr && kind == RK_SPECIAL && sel == FN_LOAD;
    assign do_cfg   = wr && kind == RK_SPECIAL && sel == FN_CFG;

    logic [15:0] data_q   [NCH];
    logic [1:0]  coarse_q [NCH];
    logic [5:0]  fine_q   [NCH];
    logic [7:0]  offs_q   [NCH];
    logic [15:0] outc_q   [NCH];
    logic [15:0] cfg_q, rdbuf_q, rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                data_q[i]   <= MID_CODE;
                coarse_q[i] <= '0;
                fine_q[i]   <= '0;
                offs_q[i]   <= '0;
                outc_q[i]   <= MID_CODE;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (do_clear)
                    data_q[i] <= MID_CODE;
                else if (wr && sel == 3'(i) && kind == RK_DATA)
                    data_q[i] <= val & CODE_MASK;
                if (wr && sel == 3'(i) && kind == RK_COARSE) coarse_q[i] <= val[1:0];
                if (wr && sel == 3'(i) && kind == RK_FINE)   fine_q[i]   <= val[5:0];
                if (wr && sel == 3'(i) && kind == RK_OFFSET) offs_q[i]   <= val[7:0];
                if (do_load) outc_q[i] <= data_q[i];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == 3'(i)) begin
                case (kind)
                    RK_DATA:   rd_val = data_q[i];
                    RK_COARSE: rd_val = {14'h0, coarse_q[i]};
                    RK_FINE:   rd_val = {10'h0, fine_q[i]};
                    RK_OFFSET: rd_val = {8'h0, offs_q[i]};
                    default:   ;
                endcase
            end
        end
        if (kind == RK_SPECIAL && sel == FN_CFG) rd_val = cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            rdbuf_q <= '0;
        end else begin
            if (do_cfg)  cfg_q   <= val;
            if (frame_v) rdbuf_q <= rd ? rd_val : 16'h0;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_out
            assign data_o[g]   = data_q[g];
            assign coarse_o[g] = coarse_q[g];
            assign fine_o[g]   = fine_q[g];
            assign offset_o[g] = offs_q[g];
            assign out_o[g]    = outc_q[g];
            if (PAD > 0) begin : g_pad
                // R2
                low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    data_o[g][PAD-1:0] == '0);
            end
        end
    endgenerate
    assign cfg_o   = cfg_q;
    assign rdbuf_o = rdbuf_q;

    // R6
    clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (data_o == {NCH{MID_CODE}}));
    // R7
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (out_o == $past(data_o)));
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> $stable(out_o));
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
    import qdac_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int RES_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 mosi,
    output logic                 miso,
    output logic [NCH-1:0][15:0] data_o,
    output logic [NCH-1:0][1:0]  coarse_o,
    output logic [NCH-1:0][5:0]  fine_o,
    output logic [NCH-1:0][7:0]  offset_o,
    output logic [NCH-1:0][15:0] out_o,
    output logic [15:0]          cfg_o
);
    logic               frame_v;
    logic [FRAME_W-1:0] frame_w;
    logic [15:0]        rdbuf;

    qdac_link u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .tx_word (rdbuf),
        .frame_v (frame_v),
        .frame_w (frame_w)
    );

    qdac_regs #(.NCH(NCH), .RES_BITS(RES_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_v  (frame_v),
        .frame_w  (frame_w),
        .data_o   (data_o),
        .coarse_o (coarse_o),
        .fine_o   (fine_o),
        .offset_o (offset_o),
        .out_o    (out_o),
        .cfg_o    (cfg_o),
        .rdbuf_o  (rdbuf)
    );
endmodule

// File: tb/quad_dac_regif_test.sv
`timescale 1ns/100ps
module quad_dac_regif_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cs_n, sclk, mosi;
    logic miso16, miso14;
    logic [3:0][15:0] d16, o16, d14, o14;
    logic [3:0][1:0]  c16, c14;
    logic [3:0][5:0]  f16, f14;
    logic [3:0][7:0]  of16, of14;
    logic [15:0]      cfg16, cfg14;

    quad_dac_regif #(.NCH(4), .RES_BITS(16)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso16),
        .data_o(d16), .coarse_o(c16), .fine_o(f16), .offset_o(of16), .out_o(o16), .cfg_o(cfg16));
    quad_dac_regif #(.NCH(4), .RES_BITS(14)) uut14 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso14),
        .data_o(d14), .coarse_o(c14), .fine_o(f14), .offset_o(of14), .out_o(o14), .cfg_o(cfg14));

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // behavioural model; index 0 = 16-bit instance, 1 = 14-bit instance
    int unsigned md [2][4];
    int unsigned mo [2][4];
    int unsigned mc [4];
    int unsigned mf [4];
    int unsigned mof [4];
    int unsigned mcfg;
    int unsigned mrd [2];
    int unsigned mask [2] = '{32'hFFFF, 32'hFFFC};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fr(input bit rd, input int kind, input int ch, input int v);
        return {rd, 4'(kind), 3'(ch), 16'(v)};
    endfunction

    function automatic void apply(input logic [23:0] w);
        int kind = int'(w[22:19]);
        int ch   = int'(w[18:16]);
        int unsigned v = int'(w[15:0]);
        for (int k = 0; k < 2; k++) begin
            int unsigned rv = 0;
            if (w[23]) begin
                if (kind == 2 && ch < 4) rv = md[k][ch];
                else if (kind == 3 && ch < 4) rv = mc[ch];
                else if (kind == 4 && ch < 4) rv = mf[ch];
                else if (kind == 5 && ch < 4) rv = mof[ch];
                else if (kind == 0 && ch == 1) rv = mcfg;
            end else begin
                if (kind == 2 && ch < 4) md[k][ch] = v & mask[k];
                if (kind == 0 && ch == 4) for (int i = 0; i < 4; i++) md[k][i] = 32'h8000;
                if (kind == 0 && ch == 5) for (int i = 0; i < 4; i++) mo[k][i] = md[k][i];
            end
            mrd[k] = rv;
        end
        if (!w[23]) begin
            if (kind == 3 && ch < 4) mc[ch] = v & 3;
            if (kind == 4 && ch < 4) mf[ch] = v & 63;
            if (kind == 5 && ch < 4) mof[ch] = v & 255;
            if (kind == 0 && ch == 1) mcfg = v;
        end
    endfunction

    function automatic logic [207:0] expb(input int k);
        logic [3:0][15:0] ed, eo;
        logic [3:0][1:0]  ec;
        logic [3:0][5:0]  ef;
        logic [3:0][7:0]  eof;
        for (int i = 0; i < 4; i++) begin
            ed[i] = 16'(md[k][i]);  eo[i] = 16'(mo[k][i]);
            ec[i] = 2'(mc[i]);      ef[i] = 6'(mf[i]);  eof[i] = 8'(mof[i]);
        end
        return {ed, eo, ec, ef, eof, 16'(mcfg)};
    endfunction

    // R1 R3 R6 R7 R8 R10: full register state against the model on every clock
    always @(negedge clk) begin
        if (cmp_en) begin
            checks += 2;
            if ({d16, o16, c16, f16, of16, cfg16} !== expb(0)) begin
                errors++;
                $display("FAIL R1 state16 act=%h exp=%h", {d16, o16, c16, f16, of16, cfg16}, expb(0));
            end
            if ({d14, o14, c14, f14, of14, cfg14} !== expb(1)) begin
                errors++;
                $display("FAIL R2 state14 act=%h exp=%h", {d14, o14, c14, f14, of14, cfg14}, expb(1));
            end
        end
    end

    task automatic xfer(input logic [23:0] w, input int nbits, input string req);
        logic [23:0] r16 = '0, r14 = '0;
        logic [15:0] e16 = 16'(mrd[0]);
        logic [15:0] e14 = 16'(mrd[1]);
        @(negedge clk) cs_n = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            mosi = (b < 24) ? w[23-b] : 1'b0;
            sclk = 1'b0;
            @(negedge clk);
            @(negedge clk);
            if (b < 24) begin
                r16[23-b] = miso16;
                r14[23-b] = miso14;
            end
            sclk = 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
        @(negedge clk) sclk = 1'b0;
        @(negedge clk);
        @(negedge clk) cs_n = 1'b1;
        @(posedge clk);
        #1;
        if (nbits == 24) apply(w);
        repeat (3) @(negedge clk);
        if (nbits >= 24) begin
            check({req, " miso16"}, 64'(r16), 64'({8'h00, e16}));
            check({req, " miso14"}, 64'(r14), 64'({8'h00, e14}));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 4; i++) begin md[k][i] = 32'h8000; mo[k][i] = 32'h8000; end
            mrd[k] = 0;
        end
        for (int i = 0; i < 4; i++) begin mc[i] = 0; mf[i] = 0; mof[i] = 0; end
        mcfg = 0;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R11 reset state
        check("R11 data", 64'(d16), {4{16'h8000}});
        check("R11 out", 64'(o16), {4{16'h8000}});
        check("R11 cfg", 64'(cfg16), 64'h0);
        xfer(fr(0, 0, 0, 0), 24, "R11 first frame zeros");

        // R1 data writes; R2 low bits dropped in 14-bit instance
        xfer(fr(0, 2, 0, 16'h1234), 24, "R1");
        xfer(fr(0, 2, 3, 16'hABCD), 24, "R1");
        check("R2 ch3 14-bit", 64'(d14[3]), 64'h0000_ABCC);

        // R4 read then zero frame (R5 no-op) returns value
        xfer(fr(1, 2, 3, 0), 24, "R4");
        xfer(fr(0, 0, 0, 0), 24, "R4 R2 readback data ch3");

        // R5 read-back frame carrying a write
        xfer(fr(1, 2, 0, 0), 24, "R4");
        xfer(fr(0, 2, 1, 16'h5557), 24, "R5 readback while writing ch1");
        check("R5 ch1 written", 64'(d16[1]), 64'h5557);

        // R3 calibration fields
        xfer(fr(0, 5, 2, 16'h1F80), 24, "R3");
        xfer(fr(0, 4, 1, 16'hFFE0), 24, "R3");
        xfer(fr(0, 3, 0, 16'hFFFF), 24, "R3");
        check("R3 offset", 64'(of16[2]), 64'h80);
        check("R3 fine", 64'(f16[1]), 64'h20);
        xfer(fr(1, 5, 2, 0), 24, "R3");
        xfer(fr(1, 4, 1, 0), 24, "R3 readback offset");
        xfer(fr(0, 0, 0, 0), 24, "R3 readback fine");
        xfer(fr(0, 0, 0, 0), 24, "R4 after non-read zeros");

        // R8 configuration
        xfer(fr(0, 0, 1, 16'hBEEF), 24, "R8");
        xfer(fr(1, 0, 1, 0), 24, "R8");
        xfer(fr(0, 0, 0, 0), 24, "R8 readback cfg");

        // R7 load, R6 clear
        xfer(fr(0, 0, 5, 0), 24, "R7");
        check("R7 out ch3", 64'(o16[3]), 64'hABCD);
        xfer(fr(0, 2, 0, 16'h0F0F), 24, "R7");
        check("R7 out holds", 64'(o16[0]), 64'h1234);
        xfer(fr(0, 0, 4, 0), 24, "R6");
        check("R6 data mid", 64'(d16), {4{16'h8000}});
        check("R6 out kept", 64'(o16[0]), 64'h1234);
        xfer(fr(1, 0, 4, 0), 24, "R6 read does not clear");
        xfer(fr(0, 0, 5, 0), 24, "R7 load mid");

        // R9 wrong-length frames
        xfer(fr(0, 2, 0, 16'h7777), 24, "R9");
        xfer(fr(1, 2, 0, 0), 24, "R9");
        xfer(fr(0, 2, 0, 16'h1111), 23, "R9");
        xfer(fr(0, 2, 0, 16'h2222), 25, "R9");
        check("R9 ch0 unchanged", 64'(d16[0]), 64'h7777);
        xfer(fr(0, 0, 0, 0), 24, "R9 pending readback kept");

        // R10 invalid addresses
        xfer(fr(0, 2, 5, 16'h4444), 24, "R10");
        xfer(fr(0, 6, 0, 16'h4444), 24, "R10");
        xfer(fr(0, 1, 2, 16'h4444), 24, "R10");
        xfer(fr(1, 2, 6, 0), 24, "R10");
        xfer(fr(0, 0, 0, 0), 24, "R10 invalid read zero");
        check("R10 ch0 unchanged", 64'(d16[0]), 64'h7777);

        cmp_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule